// File: doc/BRIEF.md
# Lock-Carried Write Signature Filter

This block is a per-core Bloom filter that summarises the addresses a core has written inside atomic regions. Each insert hashes an address with four independent XOR-based hash functions and sets the four selected bits of a 256-bit array. A membership query reports whether all four bits for an address are set, so a false hit is possible but a missed address is not.

The signature is made to travel with lock ownership. A filter received with a lock is ORed into the local one. The whole array can be emptied in one cycle when a phase ends. On thread migration it can be forced to all ones, so that every later lookup hits. The full vector is always visible on a parallel output, and can be written back in one cycle for context save and restore.

Top module: `bloom_sig`

## Requirements
- R1: After reset the array is all zeros and `sig_out` reads zero.
- R2: Hash h (0..3) of address A gives the index formed by XORing C(h,j) over every set bit j of A. C(h,j) is bits [31:24] of ((h*32 + j + 1) * 0x9E3779B9 mod 2^32) XOR 0x5A17C3E1, which is bit position C in `sig_out`.
- R3: An insert sets the four bits at the indices of R2 on the next clock edge and leaves every other bit unchanged.
- R4: `qry_hit` is combinational. It is 1 exactly when all four bits indexed by `qry_addr` are set in the array as registered, so an insert in the same cycle is not seen yet.
- R5: A clear empties the whole array in one cycle.
- R6: A merge ORs `merge_vec` into the array in one cycle.
- R7: The next array is built in this order: the base is `load_vec` if load is asserted, else zero if clear is asserted, else the current array. `merge_vec` is ORed onto the base, then the insert bits are ORed on top, and saturate forces all ones last.
- R8: Saturate makes the whole array ones, after which every query hits.
- R9: Load replaces the array with `load_vec`, and `sig_out` always shows the registered array.
- R10: Without clear or load, no set bit is ever cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert strobe |
| ins_addr | input | 32 | Address to insert |
| qry_addr | input | 32 | Address to look up |
| qry_hit | output | 1 | All four hashed bits set |
| clear | input | 1 | Flash clear |
| merge_valid | input | 1 | Merge strobe |
| merge_vec | input | 256 | Incoming signature to OR in |
| saturate | input | 1 | Force all ones |
| load_valid | input | 1 | Load strobe |
| load_vec | input | 256 | Vector to load |
| sig_out | output | 256 | Registered array contents |

## Verification
The hardest cases to reach are those where several operations arrive in the same cycle, such as clear with insert, load with merge and insert, or a query of an address that is being inserted in that cycle. Reaching them by chance needs rare operations to coincide. Directed cycles drive each of these combinations explicitly. A random phase follows, in which queries often reuse recently inserted addresses so that hits arise and not only misses.

// File: rtl/bloom_sig.sv
module bloom_sig #(
  parameter int ADDR_W = 32,
  parameter int ENTRIES = 256,
  parameter int HASHES = 4,
  parameter logic [31:0] SEED = 32'h5A17C3E1,
  parameter logic [31:0] MULT = 32'h9E3779B9,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_hit,
  input  logic              clear,
  input  logic              merge_valid,
  input  logic [ENTRIES-1:0] merge_vec,
  input  logic              saturate,
  input  logic              load_valid,
  input  logic [ENTRIES-1:0] load_vec,
  output logic [ENTRIES-1:0] sig_out
);

  function automatic logic [IDX_W-1:0] h_const(input int h, input int j);
    logic [31:0] k;
    k = (32'(h * ADDR_W + j + 1) * MULT) ^ SEED;
    return k[31 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] h_index(input int h, input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int j = 0; j < ADDR_W; j++)
      if (a[j]) r = r ^ h_const(h, j);
    return r;
  endfunction

  logic [ENTRIES-1:0] bits_q, bits_d, ins_mask;
  logic [HASHES-1:0]  qry_sel;

  always_comb begin
    ins_mask = '0;
    for (int h = 0; h < HASHES; h++) begin
      ins_mask[h_index(h, ins_addr)] = 1'b1;
      qry_sel[h] = bits_q[h_index(h, qry_addr)];
    end
  end

  assign qry_hit = &qry_sel;
  assign sig_out = bits_q;

  always_comb begin
    if (load_valid)  bits_d = load_vec;
    else if (clear)  bits_d = '0;
    else             bits_d = bits_q;
    if (merge_valid) bits_d = bits_d | merge_vec;
    if (ins_valid)   bits_d = bits_d | ins_mask;
    if (saturate)    bits_d = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

endmodule

module bloom_sig_chk #(
  parameter int ENTRIES = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic               clear,
  input logic               merge_valid,
  input logic [ENTRIES-1:0] merge_vec,
  input logic               saturate,
  input logic               load_valid,
  input logic [ENTRIES-1:0] load_vec,
  input logic [ENTRIES-1:0] sig_out
);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !load_valid && !merge_valid && !ins_valid && !saturate) |=> (sig_out == '0));

  p_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    merge_valid |=> ((sig_out & $past(merge_vec)) == $past(merge_vec)));

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    saturate |=> (&sig_out));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !merge_valid && !ins_valid && !saturate) |=> (sig_out == $past(load_vec)));

  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load_valid) |=> ((sig_out & $past(sig_out)) == $past(sig_out)));

endmodule

bind bloom_sig bloom_sig_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .clear(clear),
  .merge_valid(merge_valid), .merge_vec(merge_vec), .saturate(saturate),
  .load_valid(load_valid), .load_vec(load_vec), .sig_out(sig_out)
);

// File: tb/bloom_sig_tb_top.sv
module bloom_sig_tb_top;
  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, clear = 0, merge_valid = 0, saturate = 0, load_valid = 0;
  logic [31:0] ins_addr = 0, qry_addr = 0;
  logic [255:0] merge_vec = 0, load_vec = 0, sig_out, model;
  logic qry_hit;
  int checks = 0, failures = 0;
  logic [31:0] hist [16];

  always #4 clk = ~clk;

  bloom_sig dut_i (.clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .qry_addr(qry_addr), .qry_hit(qry_hit), .clear(clear), .merge_valid(merge_valid),
    .merge_vec(merge_vec), .saturate(saturate), .load_valid(load_valid),
    .load_vec(load_vec), .sig_out(sig_out));

  function automatic logic [7:0] idx(input int h, input logic [31:0] a);
    logic [7:0] r = 0;
    logic [31:0] k;
    for (int j = 0; j < 32; j++) if (a[j]) begin
      k = (32'(h * 32 + j + 1) * 32'h9E3779B9) ^ 32'h5A17C3E1;
      r ^= k[31:24];
    end
    return r;
  endfunction

  function automatic logic [255:0] mask_of(input logic [31:0] a);
    logic [255:0] m = 0;
    for (int h = 0; h < 4; h++) m[idx(h, a)] = 1'b1;
    return m;
  endfunction

  function automatic logic hit_of(input logic [255:0] v, input logic [31:0] a);
    return (v & mask_of(a)) == mask_of(a);
  endfunction

  function automatic logic [255:0] next_of(input logic [255:0] cur);
    logic [255:0] n;
    n = load_valid ? load_vec : (clear ? 256'd0 : cur);
    if (merge_valid) n |= merge_vec;
    if (ins_valid) n |= mask_of(ins_addr);
    if (saturate) n = '1;
    return n;
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; clear = 0; merge_valid = 0; saturate = 0; load_valid = 0;
  endtask

  // inputs are set after a negedge; query checked before posedge, state after next negedge
  task automatic step(input string req);
    logic [255:0] exp;
    #1;
    chk(qry_hit == hit_of(model, qry_addr), "R4 query", {255'd0, qry_hit}, {255'd0, hit_of(model, qry_addr)});
    exp = next_of(model);
    @(negedge clk);
    model = exp;
    chk(sig_out == exp, req, sig_out, exp);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) hist[i] = 0;
    model = 0;
    repeat (3) @(negedge clk);
    chk(sig_out == 0, "R1 reset", sig_out, 0);
    rst_n = 1;

    // R2 R3 insert sets exactly the hashed bits; R4 same-cycle query misses
    a = 32'h0000_1000; ins_valid = 1; ins_addr = a; qry_addr = a; step("R3 insert");
    chk($countones(sig_out) <= 4 && sig_out == mask_of(a), "R2 index", sig_out, mask_of(a));
    qry_addr = a; #1;
    chk(qry_hit == 1, "R4 hit after insert", {255'd0, qry_hit}, 1);
    @(negedge clk);
    // R5 clear
    clear = 1; step("R5 clear");
    // R7 clear with insert
    ins_valid = 1; ins_addr = 32'hDEAD_BEEF; step("R3 insert");
    clear = 1; ins_valid = 1; ins_addr = 32'h1234_5678; step("R7 clear+insert");
    // R6 merge + R7 merge with insert
    merge_valid = 1; merge_vec = rnd256(); step("R6 merge");
    clear = 1; merge_valid = 1; merge_vec = rnd256(); ins_valid = 1; ins_addr = 32'hCAFE_0001; step("R7 clear+merge+insert");
    // R9 load and load priority
    load_valid = 1; load_vec = rnd256(); step("R9 load");
    load_valid = 1; load_vec = 0; clear = 1; merge_valid = 1; merge_vec = 256'hF0; step("R7 load+merge");
    // R8 saturate
    saturate = 1; clear = 1; step("R8 saturate");
    qry_addr = 32'h7777_0000; #1;
    chk(qry_hit == 1, "R8 query hits", {255'd0, qry_hit}, 1);
    @(negedge clk);
    load_valid = 1; load_vec = 0; step("R9 load zero");
    // R10 random phase
    for (int c = 0; c < 2000; c++) begin
      a = $urandom;
      ins_valid = $urandom_range(0, 1); ins_addr = a;
      if (ins_valid) hist[c % 16] = a;
      merge_valid = ($urandom_range(0, 7) == 0);
      merge_vec = rnd256() & rnd256() & rnd256() & rnd256();
      clear = ($urandom_range(0, 15) == 0);
      saturate = ($urandom_range(0, 63) == 0);
      load_valid = ($urandom_range(0, 31) == 0);
      load_vec = rnd256() & rnd256();
      qry_addr = $urandom_range(0, 1) ? hist[$urandom_range(0, 15)] : $urandom;
      step("R10 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule